// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. A 16-bit line-format word sets the character length, the parity policy, the stop length and a forced-break control. A 4-bit rate index picks one of ten standard bit rates. A clock-frequency parameter sets the divisor for each rate. Bytes enter one at a time over a valid/ready handshake.

An internal tick runs at sixteen times the selected bit rate, so every bit is a whole number of ticks. This lets a stop length of one and a half bits last exactly 24 ticks. Format and rate are captured when a byte is accepted, so a frame already in flight keeps the settings it started with.

A pause input, driven by outside flow-control logic, stops a new frame from starting. The break control acts at once and pulls the line low.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever the block is idle with break clear, `txLine` is high. `inReady` is high after reset.
- R2: A frame starts with one low start bit. The data bits follow least-significant first. When format bits 7:0 hold any value other than 7, all 8 bits of the byte are sent.
- R3: When format bits 7:0 equal 7, only byte bits 6:0 are sent, and bit 7 never reaches the line.
- R4: Format bits 10:8 select a parity bit sent after the data: 1 odd, 2 even, 3 always 1, 4 always 0. Codes 0, 5, 6 and 7 send no parity bit. Odd and even parity are computed over the data bits that are actually sent.
- R5: Format bits 13:11 select the high stop period: 0 gives 16 ticks, 1 gives 24 ticks, 2 gives 32 ticks, and codes 3 to 7 give 16 ticks.
- R6: One bit lasts 16 ticks, and one tick lasts round(CLK_HZ / (16 × rate)) clock cycles. Rate index 0..9 selects 300, 600, 1200, 2400, 4800, 9600, 19200, 38400, 57600 or 115200. Indices 10..15 select 115200.
- R7: A byte is taken on a clock edge where `inValid` and `inReady` are both high. The line goes low in the next cycle. `inReady` stays low for the whole frame and rises in the cycle the stop period ends. A held `inValid` takes no second byte during a frame.
- R8: While `pause` is high, `inReady` is low and no frame starts. Raising `pause` during a frame does not change that frame.
- R9: While format bit 14 is high, `txLine` is low in the same cycle and `inReady` is low. A frame in flight keeps its timing underneath the break.
- R10: A change to the format word (other than bit 14) or to the rate index during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtWord | input | 16 | Line format: character length, parity, stop length, break |
| baudSel | input | 4 | Bit-rate index |
| pause | input | 1 | Stops a new frame from starting |
| inValid | input | 1 | A byte is offered |
| inData | input | 8 | Byte to send |
| inReady | output | 1 | Block will take the offered byte |
| txLine | output | 1 | Serial output, idles high |

## Verification
The bench compares the line with a waveform it computes itself, cycle by cycle for every frame. This catches a bit that is one tick long or short, a swapped bit order, a wrong parity sense, or a 1.5-bit stop rounded to 1 or 2 bits. It sweeps all sixteen rate indices, including the out-of-range ones and the one-cycle-per-tick divisor, where an off-by-one in the tick counter would shift every edge. It changes the format and rate in mid-frame, raises pause in mid-frame and holds `inValid` through a frame, so a design that reads its settings live, or accepts a second byte early, produces a different waveform. It also applies break at idle and in mid-frame, where a design that gated only new frames would leave the line high.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int FMT_W      = 16;
  localparam int BAUD_SEL_W = 4;
  localparam int BYTE_W     = 8;
  localparam int OVERSAMPLE = 16;
  localparam int TICK_W     = 6;
  localparam int NUM_BAUD   = 1 << BAUD_SEL_W;
  localparam int BIT_IDX_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } parMode_e;

  typedef struct packed {
    logic              use7;
    parMode_e          parMode;
    logic [TICK_W-1:0] stopTicks;
    logic              brk;
  } fmtDec_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic sendParity;
    logic sendStop;
  } txStrobes_t;

  function automatic int unsigned baudRate(input int unsigned idx);
    case (idx)
      0:       return 300;
      1:       return 600;
      2:       return 1200;
      3:       return 2400;
      4:       return 4800;
      5:       return 9600;
      6:       return 19200;
      7:       return 38400;
      8:       return 57600;
      default: return 115200;
    endcase
  endfunction

  function automatic int unsigned baudDivisor(input int unsigned clkHz, input int unsigned idx);
    int unsigned rate;
    int unsigned div;
    rate = baudRate(idx);
    div  = (clkHz + rate * 8) / (rate * OVERSAMPLE);
    return (div == 0) ? 1 : div;
  endfunction

  function automatic fmtDec_t decodeFormat(input logic [FMT_W-1:0] w);
    fmtDec_t d;
    d.use7 = (w[7:0] == 8'd7);
    case (w[10:8])
      3'd1:    d.parMode = PAR_ODD;
      3'd2:    d.parMode = PAR_EVEN;
      3'd3:    d.parMode = PAR_MARK;
      3'd4:    d.parMode = PAR_SPACE;
      default: d.parMode = PAR_NONE;
    endcase
    case (w[13:11])
      3'd1:    d.stopTicks = TICK_W'(24);
      3'd2:    d.stopTicks = TICK_W'(32);
      default: d.stopTicks = TICK_W'(16);
    endcase
    d.brk = w[14];
    return d;
  endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
  import uart_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  load,
  input  logic [BAUD_SEL_W-1:0] baudSel,
  input  logic                  running,
  output logic                  tick
);

  localparam int unsigned MAX_DIV = baudDivisor(CLK_HZ, 0);
  localparam int          DIV_W   = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] divTable [NUM_BAUD];
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] cnt;

  for (genvar g = 0; g < NUM_BAUD; g++) begin : g_div
    assign divTable[g] = DIV_W'(baudDivisor(CLK_HZ, g));
  end

  assign tick = running && (cnt == divReg - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= DIV_W'(1);
      cnt    <= '0;
    end else if (load) begin
      divReg <= divTable[baudSel];
      cnt    <= '0;
    end else if (!running || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_cnt_below_div_r6: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt < divReg));

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  fmtDec_t    fmtDec,
  input  logic       tick,
  input  logic       inValid,
  input  logic       pause,
  input  logic       brkNow,
  output logic       inReady,
  output logic       busy,
  output txStrobes_t stb
);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_e;

  phase_e                phase;
  logic [TICK_W-1:0]     tickCnt;
  logic [TICK_W-1:0]     stopTicksReg;
  logic [TICK_W-1:0]     limit;
  logic [BIT_IDX_W-1:0]  bitIdx;
  logic [BIT_IDX_W-1:0]  lastBit;
  logic                  parOn;
  logic                  tickDone;
  logic                  startReq;
  logic                  lastData;

  always_comb begin
    limit    = (phase == PH_STOP) ? stopTicksReg : TICK_W'(OVERSAMPLE);
    tickDone = tick && (tickCnt == limit - 1'b1);
    inReady  = (phase == PH_IDLE) && !pause && !brkNow;
    startReq = inValid && inReady;
    busy     = (phase != PH_IDLE);
    lastData = (phase == PH_DATA) && (bitIdx == lastBit);
  end

  always_comb begin
    stb            = '0;
    stb.load       = startReq;
    stb.shift      = tickDone && ((phase == PH_START) || ((phase == PH_DATA) && !lastData));
    stb.sendParity = tickDone && lastData && parOn;
    stb.sendStop   = tickDone && ((phase == PH_PARITY) || (lastData && !parOn));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      tickCnt      <= '0;
      bitIdx       <= '0;
      lastBit      <= BIT_IDX_W'(BYTE_W - 1);
      parOn        <= 1'b0;
      stopTicksReg <= TICK_W'(OVERSAMPLE);
    end else begin
      if (startReq || tickDone) begin
        tickCnt <= '0;
      end else if (tick) begin
        tickCnt <= tickCnt + 1'b1;
      end

      case (phase)
        PH_IDLE: begin
          if (startReq) begin
            phase        <= PH_START;
            lastBit      <= fmtDec.use7 ? BIT_IDX_W'(BYTE_W - 2) : BIT_IDX_W'(BYTE_W - 1);
            parOn        <= (fmtDec.parMode != PAR_NONE);
            stopTicksReg <= fmtDec.stopTicks;
          end
        end
        PH_START: begin
          if (tickDone) begin
            phase  <= PH_DATA;
            bitIdx <= '0;
          end
        end
        PH_DATA: begin
          if (tickDone) begin
            if (lastData) begin
              phase <= parOn ? PH_PARITY : PH_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        PH_PARITY: begin
          if (tickDone) phase <= PH_STOP;
        end
        PH_STOP: begin
          if (tickDone) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_tick_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (tickCnt < limit));

  p_load_enters_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (phase == PH_START));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.shift, stb.sendParity, stb.sendStop}));

endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        stb,
  input  fmtDec_t           fmtDec,
  input  logic [BYTE_W-1:0] inData,
  input  logic              brkNow,
  output logic              txLine
);

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] maskedData;
  logic              parBit;
  logic              parNext;
  logic              lineReg;

  always_comb begin
    maskedData = inData;
    if (fmtDec.use7) maskedData[BYTE_W-1] = 1'b0;
    case (fmtDec.parMode)
      PAR_ODD:   parNext = ~(^maskedData);
      PAR_EVEN:  parNext = ^maskedData;
      PAR_MARK:  parNext = 1'b1;
      default:   parNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      lineReg  <= 1'b1;
    end else if (stb.load) begin
      shiftReg <= inData;
      parBit   <= parNext;
      lineReg  <= 1'b0;
    end else if (stb.shift) begin
      lineReg  <= shiftReg[0];
      shiftReg <= shiftReg >> 1;
    end else if (stb.sendParity) begin
      lineReg <= parBit;
    end else if (stb.sendStop) begin
      lineReg <= 1'b1;
    end
  end

  assign txLine = lineReg && !brkNow;

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !lineReg);

  p_stop_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.sendStop |=> lineReg);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] fmtWord,
  input  logic [3:0]  baudSel,
  input  logic        pause,
  input  logic        inValid,
  input  logic [7:0]  inData,
  output logic        inReady,
  output logic        txLine
);

  fmtDec_t    fmtDec;
  txStrobes_t stb;
  logic       tick;
  logic       busy;

  assign fmtDec = decodeFormat(fmtWord);

  uart_tx_baud #(.CLK_HZ(CLK_HZ)) u_baud (
    .clk     (clk),
    .rstN    (rstN),
    .load    (stb.load),
    .baudSel (baudSel),
    .running (busy),
    .tick    (tick)
  );

  uart_tx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fmtDec  (fmtDec),
    .tick    (tick),
    .inValid (inValid),
    .pause   (pause),
    .brkNow  (fmtDec.brk),
    .inReady (inReady),
    .busy    (busy),
    .stb     (stb)
  );

  uart_tx_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .fmtDec (fmtDec),
    .inData (inData),
    .brkNow (fmtDec.brk),
    .txLine (txLine)
  );

  p_break_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    fmtWord[14] |-> !txLine);

  p_pause_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    pause |-> !inReady);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> txLine);

  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !inReady);

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  localparam int unsigned CLK_HZ = 1_843_200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] fmtWord = 16'h0008;
  logic [3:0]  baudSel = 4'd9;
  logic        pause = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inReady;
  logic        txLine;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_frame_tx #(.CLK_HZ(CLK_HZ)) u_uart_frame_tx (
    .clk(clk), .rstN(rstN), .fmtWord(fmtWord), .baudSel(baudSel), .pause(pause),
    .inValid(inValid), .inData(inData), .inReady(inReady), .txLine(txLine)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int divOf(input logic [3:0] b);
    int rate;
    case (b)
      4'd0: rate = 300;    4'd1: rate = 600;   4'd2: rate = 1200;
      4'd3: rate = 2400;   4'd4: rate = 4800;  4'd5: rate = 9600;
      4'd6: rate = 19200;  4'd7: rate = 38400; 4'd8: rate = 57600;
      default: rate = 115200;
    endcase
    return CLK_HZ / (rate * 16);
  endfunction

  // mode: 0 plain, 1 settings change (R10), 2 pause (R8), 3 break (R9), 4 held valid (R7)
  task automatic runFrame(input logic [7:0] d, input logic [15:0] f, input logic [3:0] b,
                          input int mode, input string tag);
    int n, dv, bt, nb, stopT, endC, lineErrJ, readyErrJ;
    logic par, pe, expL, expR, gotL, gotR, badL, badR;
    logic [7:0] md;
    logic bits [0:9];
    n  = (f[7:0] == 8'd7) ? 7 : 8;
    md = (n == 7) ? (d & 8'h7F) : d;
    par = (f[10:8] >= 3'd1) && (f[10:8] <= 3'd4);
    case (f[10:8])
      3'd1: pe = ~(^md);
      3'd2: pe = ^md;
      3'd3: pe = 1'b1;
      default: pe = 1'b0;
    endcase
    case (f[13:11])
      3'd1: stopT = 24;
      3'd2: stopT = 32;
      default: stopT = 16;
    endcase
    dv = divOf(b);
    bt = 16 * dv;
    bits[0] = 1'b0;
    for (int k = 0; k < 8; k++) bits[k+1] = md[k];
    bits[9] = 1'b1;
    if (par) bits[n+1] = pe;
    nb = 1 + n + (par ? 1 : 0);
    endC = nb * bt + stopT * dv;
    lineErrJ = -1; readyErrJ = -1;
    gotL = 1'b0; expL = 1'b0; gotR = 1'b0; expR = 1'b0;
    badL = 1'b0; badR = 1'b0;

    @(negedge clk);
    fmtWord = f; baudSel = b; inData = d; inValid = 1'b1;
    #1;
    check(inReady === 1'b1, {tag, " R7 ready before accept"}, int'(inReady), 1);
    @(posedge clk);
    @(negedge clk);
    if (mode != 4) inValid = 1'b0;
    inData = ~d;
    for (int j = 0; j <= endC; j++) begin
      if (j > 0) @(negedge clk);
      if (mode == 1 && j == bt + 3) begin
        fmtWord = 16'h1307;
        baudSel = (b == 4'd9) ? 4'd8 : 4'd9;
      end
      if (mode == 2 && j == 5) pause = 1'b1;
      if (mode == 3 && j == bt + 2) fmtWord = f | 16'h4000;
      if (mode == 3 && j == bt + 22) fmtWord = f;
      if (mode == 4 && j == endC) inValid = 1'b0;
      #1;
      expL = (j < nb * bt) ? bits[j / bt] : 1'b1;
      if (mode == 3 && j >= bt + 2 && j < bt + 22) expL = 1'b0;
      expR = (j >= endC) && (mode != 2);
      if (txLine !== expL && lineErrJ < 0) begin
        lineErrJ = j; gotL = txLine; badL = expL;
      end
      if (inReady !== expR && readyErrJ < 0) begin
        readyErrJ = j; gotR = inReady; badR = expR;
      end
    end
    fmtWord = f; baudSel = b; inValid = 1'b0;
    if (lineErrJ >= 0) $display("  (line mismatch at cycle %0d of frame)", lineErrJ);
    check(lineErrJ < 0, {tag, " line waveform"}, int'(gotL), int'(badL));
    if (readyErrJ >= 0) $display("  (ready mismatch at cycle %0d of frame)", readyErrJ);
    check(readyErrJ < 0, {tag, " R7 ready timing"}, int'(gotR), int'(badR));

    if (mode == 2) begin
      inValid = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); #1;
        check(txLine === 1'b1 && inReady === 1'b0, "R8 paused idle holds",
              int'({txLine, inReady}), 2);
      end
      @(negedge clk);
      inValid = 1'b0; pause = 1'b0;
      #1;
      check(inReady === 1'b1, "R8 ready after pause release", int'(inReady), 1);
    end
  endtask

  initial begin
    repeat (195_000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog R7 run did not finish actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(txLine === 1'b1, "R1 line high in reset", int'(txLine), 1);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(txLine === 1'b1, "R1 line high after reset", int'(txLine), 1);
    check(inReady === 1'b1, "R1 ready after reset", int'(inReady), 1);

    // R2 R3 R4 R5: sweep lengths, parity codes, stop codes and data patterns
    for (int i = 0; i < 64; i++) begin
      logic [7:0]  dLen;
      logic [15:0] f;
      case (i % 4)
        0: dLen = 8'd8;
        1: dLen = 8'd7;
        2: dLen = 8'd5;
        default: dLen = 8'd0;
      endcase
      f = {2'b00, 3'((i + i / 8) % 4), 3'((i / 4) % 8), dLen};
      runFrame(8'(i * 37 + 5), f, (i % 2 == 1) ? 4'd8 : 4'd9, 0, "R2 R3 R4 R5");
    end
    runFrame(8'hFF, 16'h0907, 4'd9, 0, "R3 R5 bit7 dropped");
    runFrame(8'h80, 16'h0107, 4'd9, 0, "R3 R4 odd over 7 bits");

    // R6: every rate index
    for (int b = 0; b < 16; b++) begin
      runFrame(8'h55, 16'h0007, 4'(b), 0, "R6 rate index");
    end

    runFrame(8'hC3, 16'h0208, 4'd9, 1, "R10 mid-frame change");
    runFrame(8'h3C, 16'h0808, 4'd8, 2, "R8 mid-frame pause");
    runFrame(8'h96, 16'h0108, 4'd9, 3, "R9 mid-frame break");
    runFrame(8'hA7, 16'h0408, 4'd9, 4, "R7 held valid");

    // R9: break at idle
    @(negedge clk);
    fmtWord = 16'h4008; inValid = 1'b1; inData = 8'h00;
    #1;
    check(txLine === 1'b0, "R9 break drives low at once", int'(txLine), 0);
    check(inReady === 1'b0, "R9 break blocks ready", int'(inReady), 0);
    repeat (5) @(negedge clk);
    #1;
    check(txLine === 1'b0, "R9 break held low", int'(txLine), 0);
    fmtWord = 16'h0008; inValid = 1'b0;
    #1;
    check(txLine === 1'b1, "R9 line high after break", int'(txLine), 1);
    begin
      int lowSeen;
      lowSeen = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk); #1;
        if (txLine !== 1'b1) lowSeen++;
      end
      check(lowSeen == 0, "R9 no byte taken during break", lowSeen, 0);
    end
    runFrame(8'h5A, 16'h1008, 4'd9, 0, "R9 R5 frame after break");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule